// File: doc/BRIEF.md
# Conversion Start Strobe and Transfer Window Scheduler

This block runs on the host side of a sampling ADC that is read over a serial link. It produces the conversion-start strobe, follows where the converter is within each sampling period, and decides when the host's serial engine may begin a read or write transaction. A conversion begins on each rising edge of the strobe and keeps the converter busy for a fixed time. A guard interval closes off the end of every period before the next rising edge. A transaction is granted only when it fits entirely between the end of the busy interval and the start of the guard interval.

All intervals are given in nanoseconds and converted to whole clock cycles, rounding up. In square-wave mode the strobe is high for a programmable time and low for another. Its falling edge raises the data-ready pulse. In narrow-pulse mode the strobe is high for only a few cycles. The rising edge raises a start interrupt, and data-ready follows once a conversion-length delay has expired. An enable input starts and stops the periodic strobe. Stopping always lets the running period finish. If the serial engine reports activity while the converter is busy or inside the guard interval, a sticky violation flag is set, and software clears it with a write-one-to-clear pulse.

Top module: `conv_sched`

## Requirements
- R1: After synchronous reset, every output is low. No strobe edge appears until `en` is sampled high.
- R2: In square-wave mode (`mode_pulse`=0), each period begins with a rising edge of `conv_start`. The strobe then stays high for HIGH cycles and low for LOW cycles, so the period is HIGH+LOW cycles. Strobe periods follow each other without a gap while `en` stays high.
- R3: In narrow-pulse mode (`mode_pulse`=1), `conv_start` is high for PULSE cycles at the start of each HIGH+LOW period. `start_irq` is a one-cycle pulse in the cycle where the strobe rises.
- R4: `conv_busy` is high for the first CONV cycles of every period, starting with the rising edge of the strobe, in both modes.
- R5: `drdy_irq` is a one-cycle pulse. In square-wave mode it comes in the cycle where the strobe falls, which is phase HIGH. In narrow-pulse mode it comes at phase CONV.
- R6: Each interval is its nanosecond parameter times 1000, divided by CLK_PS and rounded up to a whole number of cycles. The measured high time of the strobe equals HIGH in square-wave mode and PULSE in narrow-pulse mode.
- R7: `gnt` is a one-cycle pulse. It is raised at period phase p only when all of these hold: `req` is high, `req_len` is at least 1, p is at least CONV, and p+`req_len` is at most HIGH+LOW-GUARD. A request that does not fit stays pending and is granted later, in a window where it does fit.
- R8: `xfer_act` is high for exactly `req_len` cycles, beginning with the grant cycle. No new grant is given while a granted transfer is still running, or in the cycle right after a grant.
- R9: The mode is sampled only at the start of a period. A change of `mode_pulse` partway through a period takes effect at the next rising edge.
- R10: When `en` drops, the current period runs to its end and the strobe then stays low. When `en` is raised again, a full new period starts on the next cycle.
- R11: `viol` is set in the cycle after `eng_busy` is high while the converter is busy or the period is in its guard interval (phase at least HIGH+LOW-GUARD). It stays set until a cycle with `viol_clr` high, and a new set event in that same cycle wins over the clear.
- R12: No grant is given while the strobe generator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the periodic conversion strobe |
| mode_pulse | input | 1 | 0 selects square-wave mode, 1 selects narrow-pulse mode |
| req | input | 1 | Transfer request, held until granted |
| req_len | input | LEN_W | Length of the requested transfer in cycles |
| eng_busy | input | 1 | Serial engine reports activity on the link |
| viol_clr | input | 1 | Write-one-to-clear for the violation flag |
| conv_start | output | 1 | Conversion-start strobe; a conversion begins on its rising edge |
| conv_busy | output | 1 | Converter is inside its conversion interval |
| start_irq | output | 1 | Start interrupt pulse (narrow-pulse mode) |
| drdy_irq | output | 1 | Data-ready interrupt pulse |
| gnt | output | 1 | Transfer granted this cycle |
| xfer_act | output | 1 | Granted transfer occupies this cycle |
| viol | output | 1 | Sticky transfer timing violation |

## Verification
The hardest cases to reach are the ones that depend on the exact phase. One is a transfer whose length fills the whole space between the end of the busy interval and the start of the guard interval, so it can only start at one phase. Another is a request that is one cycle too long, so it must never be granted. A third is engine activity inside the guard interval in the same cycle as a clear. The bench holds long requests up across period boundaries, which makes the grant depend on the window reopening at exactly phase CONV. It places engine activity and clear pulses by following the phase of its own reference model, so they land on chosen phases within a period.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic {
    MODE_SQUARE = 1'b0,
    MODE_PULSE  = 1'b1
  } strobe_mode_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen #(
  parameter int PER  = 8,
  parameter int PH_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 mode_in,
  output logic                 run_q,
  output logic [PH_W-1:0]      ph_q,
  output logic                 run_n,
  output logic [PH_W-1:0]      ph_n,
  output cs_pkg::strobe_mode_e mode_n
);
  import cs_pkg::*;

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PER - 1);

  strobe_mode_e mode_q;
  logic         at_boundary;

  // a new period may begin only from idle or from the last phase
  assign at_boundary = !run_q || (ph_q == LAST_PH);

  always_comb begin
    if (at_boundary) begin
      run_n = en;
      ph_n  = '0;
    end else begin
      run_n = 1'b1;
      ph_n  = ph_q + PH_W'(1);
    end
    mode_n = (at_boundary && en) ? strobe_mode_e'(mode_in) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      mode_q <= MODE_SQUARE;
    end else begin
      run_q  <= run_n;
      ph_q   <= ph_n;
      mode_q <= mode_n;
    end
  end

endmodule

// File: rtl/cs_strobe_dec.sv
module cs_strobe_dec #(
  parameter int PH_W    = 4,
  parameter int CONV_C  = 2,
  parameter int HIGH_C  = 4,
  parameter int PULSE_C = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_n,
  input  logic [PH_W-1:0]      ph_n,
  input  cs_pkg::strobe_mode_e mode_n,
  output logic                 conv_start,
  output logic                 conv_busy,
  output logic                 start_irq,
  output logic                 drdy_irq
);
  import cs_pkg::*;

  int   hi_len;
  int   rdy_ph;
  logic is_pulse;

  assign is_pulse = (mode_n == MODE_PULSE);
  assign hi_len   = is_pulse ? PULSE_C : HIGH_C;
  assign rdy_ph   = is_pulse ? CONV_C : HIGH_C;

  // outputs are registered from the next phase so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      conv_busy  <= 1'b0;
      start_irq  <= 1'b0;
      drdy_irq   <= 1'b0;
    end else begin
      conv_start <= run_n && (int'(ph_n) < hi_len);
      conv_busy  <= run_n && (int'(ph_n) < CONV_C);
      start_irq  <= run_n && is_pulse && (ph_n == '0);
      drdy_irq   <= run_n && (int'(ph_n) == rdy_ph);
    end
  end

endmodule

// File: rtl/cs_xfer_arb.sv
module cs_xfer_arb #(
  parameter int PH_W   = 4,
  parameter int LEN_W  = 8,
  parameter int CONV_C = 2,
  parameter int BND    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_q,
  input  logic [PH_W-1:0]  ph_q,
  input  logic             run_n,
  input  logic [PH_W-1:0]  ph_n,
  input  logic             req,
  input  logic [LEN_W-1:0] req_len,
  input  logic             eng_busy,
  input  logic             viol_clr,
  output logic             gnt,
  output logic             xfer_act,
  output logic             viol
);
  logic [LEN_W-1:0] rem_q;
  logic             fits;
  logic             free;
  logic             take;
  logic             keepout;

  // the transfer would start at ph_n and must end by the guard boundary
  assign fits = run_n && (int'(ph_n) >= CONV_C)
             && (int'(ph_n) + int'(req_len) <= BND) && (req_len != '0);
  assign free = (rem_q <= LEN_W'(1)) && !gnt;
  assign take = req && fits && free;

  assign keepout = run_q && ((int'(ph_q) < CONV_C) || (int'(ph_q) >= BND));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= 1'b0;
      rem_q <= '0;
      viol  <= 1'b0;
    end else begin
      gnt <= take;
      if (take)              rem_q <= req_len;
      else if (rem_q != '0)  rem_q <= rem_q - LEN_W'(1);
      viol <= (viol && !viol_clr) || (keepout && eng_busy);
    end
  end

  assign xfer_act = (rem_q != '0);

endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int CLK_PS   = 4000,
  parameter int CONV_NS  = 5900,
  parameter int GUARD_NS = 500,
  parameter int HIGH_NS  = 5900,
  parameter int LOW_NS   = 5900,
  parameter int PULSE_NS = 100,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_pulse,
  input  logic             req,
  input  logic [LEN_W-1:0] req_len,
  input  logic             eng_busy,
  input  logic             viol_clr,
  output logic             conv_start,
  output logic             conv_busy,
  output logic             start_irq,
  output logic             drdy_irq,
  output logic             gnt,
  output logic             xfer_act,
  output logic             viol
);
  import cs_pkg::*;

  localparam int CONV_C  = ns_to_cyc(CONV_NS, CLK_PS);
  localparam int GUARD_C = ns_to_cyc(GUARD_NS, CLK_PS);
  localparam int HIGH_C  = ns_to_cyc(HIGH_NS, CLK_PS);
  localparam int LOW_C   = ns_to_cyc(LOW_NS, CLK_PS);
  localparam int PULSE_C = ns_to_cyc(PULSE_NS, CLK_PS);
  localparam int PER     = HIGH_C + LOW_C;
  localparam int BND     = PER - GUARD_C;
  localparam int PH_W    = $clog2(PER + 1);

  logic            run_q;
  logic            run_n;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_n;
  strobe_mode_e    mode_n;

  cs_phase_gen #(.PER(PER), .PH_W(PH_W)) phase_i (
    .clk(clk), .rst(rst), .en(en), .mode_in(mode_pulse),
    .run_q(run_q), .ph_q(ph_q), .run_n(run_n), .ph_n(ph_n), .mode_n(mode_n)
  );

  cs_strobe_dec #(
    .PH_W(PH_W), .CONV_C(CONV_C), .HIGH_C(HIGH_C), .PULSE_C(PULSE_C)
  ) strobe_i (
    .clk(clk), .rst(rst), .run_n(run_n), .ph_n(ph_n), .mode_n(mode_n),
    .conv_start(conv_start), .conv_busy(conv_busy),
    .start_irq(start_irq), .drdy_irq(drdy_irq)
  );

  cs_xfer_arb #(
    .PH_W(PH_W), .LEN_W(LEN_W), .CONV_C(CONV_C), .BND(BND)
  ) arb_i (
    .clk(clk), .rst(rst), .run_q(run_q), .ph_q(ph_q),
    .run_n(run_n), .ph_n(ph_n), .req(req), .req_len(req_len),
    .eng_busy(eng_busy), .viol_clr(viol_clr),
    .gnt(gnt), .xfer_act(xfer_act), .viol(viol)
  );

endmodule

// File: rtl/cs_checker.sv
module cs_checker (
  input logic clk,
  input logic rst,
  input logic conv_start,
  input logic conv_busy,
  input logic start_irq,
  input logic drdy_irq,
  input logic gnt,
  input logic xfer_act,
  input logic viol,
  input logic viol_clr
);

  AST_GNT_OUTSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    gnt |-> !conv_busy); // R7

  AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !gnt); // R8

  AST_GNT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    gnt |-> xfer_act); // R8

  AST_BUSY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> conv_busy); // R4

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    start_irq |-> $rose(conv_start)); // R3

  AST_DRDY_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
    drdy_irq |-> !conv_busy); // R5

  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    viol && !viol_clr |=> viol); // R11

endmodule

bind conv_sched cs_checker chk_i (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_busy(conv_busy),
  .start_irq(start_irq), .drdy_irq(drdy_irq), .gnt(gnt),
  .xfer_act(xfer_act), .viol(viol), .viol_clr(viol_clr)
);

// File: tb/conv_sched_tb_top.sv
module conv_sched_tb_top;

  localparam int CLKPS = 4000;
  localparam int CNS = 98;
  localparam int GNS = 30;
  localparam int HNS = 110;
  localparam int LNS = 90;
  localparam int PNS = 10;
  localparam int LW  = 12;

  // expected cycle counts, rounded up
  localparam int TC   = (CNS * 1000 + CLKPS - 1) / CLKPS;
  localparam int TG   = (GNS * 1000 + CLKPS - 1) / CLKPS;
  localparam int TH   = (HNS * 1000 + CLKPS - 1) / CLKPS;
  localparam int TL   = (LNS * 1000 + CLKPS - 1) / CLKPS;
  localparam int TP   = (PNS * 1000 + CLKPS - 1) / CLKPS;
  localparam int TPER = TH + TL;
  localparam int TBND = TPER - TG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic mode_pulse = 1'b0;
  logic req = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic eng_busy = 1'b0;
  logic viol_clr = 1'b0;
  logic conv_start, conv_busy, start_irq, drdy_irq, gnt, xfer_act, viol;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  conv_sched #(
    .CLK_PS(CLKPS), .CONV_NS(CNS), .GUARD_NS(GNS), .HIGH_NS(HNS),
    .LOW_NS(LNS), .PULSE_NS(PNS), .LEN_W(LW)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode_pulse(mode_pulse), .req(req),
    .req_len(req_len), .eng_busy(eng_busy), .viol_clr(viol_clr),
    .conv_start(conv_start), .conv_busy(conv_busy), .start_irq(start_irq),
    .drdy_irq(drdy_irq), .gnt(gnt), .xfer_act(xfer_act), .viol(viol)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising clock edge
  bit m_run, m_mode, m_gnt, m_viol;
  int m_ph, m_rem;
  bit n_run, n_g, n_viol;
  int n_ph;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_run = 0; m_ph = 0; m_mode = 0; m_rem = 0; m_gnt = 0; m_viol = 0;
    end else begin
      n_viol = (m_viol && !viol_clr) ||
               (m_run && eng_busy && (m_ph < TC || m_ph >= TBND));
      if (!m_run || m_ph == TPER - 1) begin
        n_run = en; n_ph = 0;
        if (en) m_mode = mode_pulse;
      end else begin
        n_run = 1; n_ph = m_ph + 1;
      end
      n_g = req && n_run && n_ph >= TC && (n_ph + int'(req_len)) <= TBND &&
            req_len != 0 && m_rem <= 1 && !m_gnt;
      if (n_g) m_rem = int'(req_len);
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_gnt = n_g; m_run = n_run; m_ph = n_ph; m_viol = n_viol;
    end
  end

  // compare every cycle away from the active edge
  int  hi_cnt = 0;
  bit  prev_cs = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R3 R9 R10 conv_start", conv_start,
          m_run && (m_ph < (m_mode ? TP : TH)));
      chk("R4 conv_busy", conv_busy, m_run && m_ph < TC);
      chk("R3 start_irq", start_irq, m_run && m_mode && m_ph == 0);
      chk("R5 drdy_irq", drdy_irq, m_run && (m_ph == (m_mode ? TC : TH)));
      chk("R7 R12 gnt", gnt, m_gnt);
      chk("R8 xfer_act", xfer_act, m_rem != 0);
      chk("R11 viol", viol, m_viol);
      if (conv_start) hi_cnt++;
      else if (prev_cs) begin
        chk_int("R6 strobe high time", hi_cnt, m_mode ? TP : TH);
        hi_cnt = 0;
      end
      prev_cs = conv_start;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic xfer(input int len, input int tmo);
    @(negedge clk);
    req = 1'b1; req_len = LW'(len);
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (gnt) break;
    end
    req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ph(input int p);
    @(negedge clk);
    while (m_ph != p) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs quiet after reset
    chk("R1 reset outputs", conv_start | conv_busy | start_irq | drdy_irq |
        gnt | xfer_act | viol, 1'b0);
    // R12: request while stopped
    req = 1'b1; req_len = LW'(4);
    repeat (8) @(negedge clk);
    req = 1'b0;
    // square-wave mode, various lengths
    en = 1'b1; mode_pulse = 1'b0;
    xfer(1, 200);
    xfer(1, 200);
    xfer(15, 200);
    xfer(TBND - TC, 200);       // R7 exactly fills the window
    xfer(TBND - TC + 1, 120);   // R7 never fits
    xfer(0, 60);                // R7 zero length ignored
    xfer(6, 200);
    // R11 engine activity in and out of the safe window
    wait_ph(30); eng_busy = 1'b1; repeat (5) @(negedge clk); eng_busy = 1'b0;
    wait_ph(TBND + 2); eng_busy = 1'b1; @(negedge clk); eng_busy = 1'b0;
    repeat (3) @(negedge clk);
    viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
    wait_ph(2); eng_busy = 1'b1; viol_clr = 1'b1; @(negedge clk);
    eng_busy = 1'b0; viol_clr = 1'b0;
    repeat (3) @(negedge clk);
    viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
    // R9 mode change partway through a period
    wait_ph(10); mode_pulse = 1'b1;
    repeat (2 * TPER) @(negedge clk);
    xfer(10, 200);
    // R10 stop mid-period, then restart
    wait_ph(20); en = 1'b0;
    repeat (80) @(negedge clk);
    en = 1'b1; mode_pulse = 1'b0;
    repeat (2 * TPER + 5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule